// File: doc/BRIEF.md
# OTG One-Shot Countdown Timer

This block is a single-shot countdown timer that runs on the device clock (nominally 60 MHz) and is programmed through one 32-bit control word. Software writes the word with its arm flag (bit 31) set and a 27-bit tick count in bits 26:0. The timer then counts down. When the count runs out it raises a timeout event into a 32-bit pending-set vector, at a fixed position (bit 16), for the interrupt controller to collect.

A write with the arm flag clear is a cancel, not a pause. Any expiry that was pending is dropped and no event is raised. The control word always reads back as the last value written. After an expiry it reads back as zero, because on expiry the whole word clears itself. Masking and aggregation of the event happen outside this block.

Top module: `otg_oneshot_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, the read data is 0 and the event vector is all zero.
- R2: A write stores the full 32-bit word, and the read data shows it from the cycle after the write edge.
- R3: A write with bit 31 set and count N (bits 26:0) expires on the (N+1)-th rising edge after the write edge, so a count of 0 expires on the very next edge.
- R4: In the same cycle that the event appears, the read data becomes 0 and stays 0 until the next write.
- R5: The event is exactly one cycle long. It appears only on bit 16 of the 32-bit event vector, and every other bit stays 0.
- R6: A write with bit 31 clear stores its value, cancels any countdown in progress, and no event follows.
- R7: A write with bit 31 set during a countdown discards the old count and restarts from the new count.
- R8: If a write lands on the same edge where an expiry would happen, the write wins: no event is raised for the old countdown, and the word is not cleared.
- R9: Bits 30:27 are stored and read back as written, and they do not change the expiry timing.
- R10: The timer is single-shot. After an expiry, or while it is idle, no further event appears until it is armed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock; one count tick per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value to write: arm flag in bit 31, count in bits 26:0 |
| rd_data | output | 32 | Current value of the control word |
| evt_set | output | 32 | Pending-set vector; bit 16 pulses on expiry |

## Verification
The write strobe is applied at a falling edge and is captured by the next rising edge, called E0. From that edge the read data is due one half-cycle later. The timeout event and the cleared word are both due after edge E(N+1). The event then drops after E(N+2).

Each scenario task waits exactly that many falling edges, checking at every one of them that no early event has appeared. It then samples the event and the read data at the falling edge that follows E(N+1). Cancel, restart and write-on-expiry cases place their second write on a counted falling edge, so that the collision lands on the intended rising edge.

// File: rtl/otg_tmr_pkg.sv
// Package: shared sizes and the decoded command type for the one-shot timer.
// Assumes a 32-bit control word with the arm flag above a 27-bit count.
package otg_tmr_pkg;
    localparam int unsigned TMR_REG_W   = 32;
    localparam int unsigned TMR_CNT_W   = 27;
    localparam int unsigned TMR_ARM_BIT = 31;
    localparam int unsigned TMR_EVT_W   = 32;
    localparam int unsigned TMR_EVT_BIT = 16;

    typedef struct packed {
        logic load;
        logic cancel;
    } tmr_cmd_t;
endpackage

// File: rtl/otg_tmr_cmd_dec.sv
// Module: turns a write strobe plus arm flag into a load or cancel command.
// Assumes the strobe lasts one cycle per write; produces no state.
module otg_tmr_cmd_dec
    import otg_tmr_pkg::*;
#(
    parameter int unsigned CNT_W = TMR_CNT_W
) (
    input  logic             wr_en,
    input  logic             arm_bit,
    input  logic [CNT_W-1:0] cnt_field,
    output tmr_cmd_t         cmd,
    output logic [CNT_W-1:0] load_val
);
    // Classify the write: armed writes load, unarmed writes cancel.
    always_comb begin
        cmd.load   = wr_en & arm_bit;
        cmd.cancel = wr_en & ~arm_bit;
        load_val   = cnt_field;
    end
endmodule

// File: rtl/otg_tmr_counter.sv
// Module: down counter with a run flag; flags expiry when a running count is 0.
// Assumes load and cancel are never both high; load wins over a same-edge expiry.
module otg_tmr_counter
    import otg_tmr_pkg::*;
#(
    parameter int unsigned CNT_W = TMR_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_cmd_t         cmd,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire,
    output logic             running
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt;

    // Expiry: the count has run out and no new command overrides it this edge.
    always_comb begin
        expire = running && (cnt == CNT_ZERO) && !cmd.load && !cmd.cancel;
    end

    // Count state: load, cancel, tick down, or stop after the final tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= CNT_ZERO;
        end else if (cmd.load) begin
            running <= 1'b1;
            cnt     <= load_val;
        end else if (cmd.cancel) begin
            running <= 1'b0;
        end else if (running) begin
            if (cnt == CNT_ZERO) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - CNT_ONE;
            end
        end
    end

    // R6
    cancel_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.cancel |=> !running);

    // R7
    load_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.load |=> (running && cnt == $past(load_val)));

    // R3
    tick_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt != CNT_ZERO && !cmd.load && !cmd.cancel)
        |=> (cnt == $past(cnt) - CNT_ONE));

    // R10
    single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !running);
endmodule

// File: rtl/otg_tmr_ctrl_reg.sv
// Module: the readable control word; takes writes, clears itself on expiry.
// Assumes a write on the expiry edge takes priority over the clear.
module otg_tmr_ctrl_reg
    import otg_tmr_pkg::*;
#(
    parameter int unsigned REG_W = TMR_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             expire,
    output logic [REG_W-1:0] value
);
    // Hold the last written word, or zero once the countdown has expired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_data;
        end else if (expire) begin
            value <= '0;
        end
    end

    // R2
    write_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (value == $past(wr_data)));

    // R4
    expiry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !wr_en) |=> (value == '0));
endmodule

// File: rtl/otg_tmr_evt.sv
// Module: registers the expiry and places it as a one-cycle set pulse on a fixed bit.
// Assumes the expiry input is high for at most one cycle per arming.
module otg_tmr_evt
    import otg_tmr_pkg::*;
#(
    parameter int unsigned EVT_W   = TMR_EVT_W,
    parameter int unsigned EVT_BIT = TMR_EVT_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    output logic [EVT_W-1:0] evt_set
);
    logic evt_q;

    // Register the expiry so the event leaves the block from a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= expire;
        end
    end

    // Route the pulse to its pending bit; tie every other bit low.
    for (genvar b = 0; b < EVT_W; b++) begin : g_evt_bit
        if (b == EVT_BIT) begin : g_hit
            assign evt_set[b] = evt_q;
        end else begin : g_zero
            assign evt_set[b] = 1'b0;
        end
    end

    // R5
    one_cycle_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |=> !evt_q);

    // R5
    evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_set));
endmodule

// File: rtl/otg_oneshot_timer.sv
// Module: top of the one-shot countdown timer. The control word carries an
// arm flag and a tick count; expiry clears the word and pulses a pending bit.
// Assumes a single-cycle write strobe and a synchronous active-low reset.
module otg_oneshot_timer
    import otg_tmr_pkg::*;
#(
    parameter int unsigned REG_W   = TMR_REG_W,
    parameter int unsigned CNT_W   = TMR_CNT_W,
    parameter int unsigned ARM_BIT = TMR_ARM_BIT,
    parameter int unsigned EVT_W   = TMR_EVT_W,
    parameter int unsigned EVT_BIT = TMR_EVT_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [EVT_W-1:0] evt_set
);
    tmr_cmd_t         cmd;
    logic [CNT_W-1:0] load_val;
    logic             expire;
    logic             running;

    otg_tmr_cmd_dec #(.CNT_W(CNT_W)) u_dec (
        .wr_en     (wr_en),
        .arm_bit   (wr_data[ARM_BIT]),
        .cnt_field (wr_data[CNT_W-1:0]),
        .cmd       (cmd),
        .load_val  (load_val)
    );

    otg_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .load_val (load_val),
        .expire   (expire),
        .running  (running)
    );

    otg_tmr_ctrl_reg #(.REG_W(REG_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .expire  (expire),
        .value   (rd_data)
    );

    otg_tmr_evt #(.EVT_W(EVT_W), .EVT_BIT(EVT_BIT)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .evt_set (evt_set)
    );

    // R6
    no_evt_after_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[ARM_BIT]) |=> (evt_set == '0));

    // R8
    write_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (evt_set == '0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_en) |=> (evt_set == '0));
endmodule

// File: tb/test_otg_oneshot_timer.sv
module test_otg_oneshot_timer;
    localparam logic [31:0] EVT_HIT = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] evt_set;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    otg_oneshot_timer i_otg_oneshot_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .evt_set (evt_set)
    );

    always #10 clk = ~clk;

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    // Drive a write at the current falling edge; it is captured on the next rising edge.
    task automatic write_word(logic [31:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // Called just after a write: wait N quiet edges, then expect the event and a cleared word.
    task automatic expect_expiry(string req, logic [31:0] v, int n);
        check_eq(req, "readback after write", rd_data, v);
        check_eq(req, "no event right after write", evt_set, '0);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            check_eq(req, "no early event", evt_set, '0);
            check_eq(req, "word held while counting", rd_data, v);
        end
        @(negedge clk);
        check_eq(req, "event on bit 16 (R5)", evt_set, EVT_HIT);
        check_eq(req, "word cleared on expiry (R4)", rd_data, '0);
        @(negedge clk);
        check_eq(req, "event lasts one cycle (R5)", evt_set, '0);
        check_eq(req, "word stays cleared (R4)", rd_data, '0);
    endtask

    task automatic quiet_cycles(string req, int n, logic [31:0] v);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_eq(req, "no event while idle", evt_set, '0);
            check_eq(req, "word unchanged while idle", rd_data, v);
        end
    endtask

    task automatic t_reset;
        check_eq("R1", "read data in reset", rd_data, '0);
        check_eq("R1", "event in reset", evt_set, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "read data after reset", rd_data, '0);
        check_eq("R1", "event after reset", evt_set, '0);
    endtask

    task automatic t_zero_count;
        write_word(32'h8000_0000);
        expect_expiry("R3", 32'h8000_0000, 0);
    endtask

    task automatic t_count_five;
        write_word(32'h8000_0005);
        expect_expiry("R2", 32'h8000_0005, 5);
        quiet_cycles("R10", 10, '0);
    endtask

    task automatic t_upper_bits;
        write_word(32'hF800_0014);
        expect_expiry("R9", 32'hF800_0014, 20);
    endtask

    task automatic t_cancel;
        write_word(32'h8000_000A);
        repeat (3) @(negedge clk);
        write_word(32'h0000_1234);
        check_eq("R6", "cancel value stored", rd_data, 32'h0000_1234);
        quiet_cycles("R6", 20, 32'h0000_1234);
    endtask

    task automatic t_restart;
        write_word(32'h8000_0010);
        repeat (4) @(negedge clk);
        write_word(32'h8000_0003);
        expect_expiry("R7", 32'h8000_0003, 3);
    endtask

    task automatic t_write_on_expiry;
        write_word(32'h8000_0002);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check_eq("R8", "no event before collision", evt_set, '0);
        end
        write_word(32'h8000_0001);
        expect_expiry("R8", 32'h8000_0001, 1);
    endtask

    task automatic t_idle_cancel;
        write_word(32'h0000_0000);
        quiet_cycles("R10", 8, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_zero_count();
        t_count_five();
        t_upper_bits();
        t_cancel();
        t_restart();
        t_write_on_expiry();
        t_idle_cancel();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule